// File: doc/BRIEF.md
# Daisy-Chained Time Slot Token Delay

Several codecs can share one TDM serial bus by passing a one-slot-wide token from device to device. Each device claims the slots that follow the token's arrival, and forwards the token a fixed number of slots later. This block produces that forwarded token. The bus master has no predecessor, so its token source is its own frame sync. A slave's source is the token that the previous device in the chain drives onto `token_in`.

Time is counted in slots. A one-clock `slot_strobe` opens every slot. `frame_sync` is raised together with the strobe that opens slot 0 of each frame. The source value of a slot is captured by the strobe that closes that slot. It then walks a six-stage shift line that advances only on strobes. The output taps either the third or the sixth stage.

The mode and the delay select are sampled only at the start of a frame. A setting therefore applies to one whole frame, both to the choice of source and to the output tap.

Top module: `slot_token_delay`

## Requirements
- R1: While `rst_n` is low at a clock edge, `token_out` is low after that edge. After reset it stays low until a source slot has travelled the full delay.
- R2: In slave mode, `token_out` is high during slot m+D whenever `token_in` was high during slot m. `token_in` is sampled by the strobe that closes slot m.
- R3: The delay D is 3 slots when the latched select is 0 and 6 slots when it is 1.
- R4: In master mode, the source of slot f is 1 exactly when f opened with `frame_sync`, and 0 for every other slot. `token_out` is therefore high for the single slot f+D, once per frame.
- R5: In master mode, `token_in` has no effect on `token_out`.
- R6: `token_out` changes only on the clock edge of a `slot_strobe`. Between strobes it holds its value.
- R7: `master_mode` and `long_delay` are latched only at the clock edge where `frame_sync` and `slot_strobe` are both high. Changes at other times have no effect until then. The latched pair governs the source and the tap for every slot of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame start, high with the strobe that opens slot 0 |
| slot_strobe | input | 1 | One-clock pulse opening each slot |
| token_in | input | 1 | Token from the preceding device, held for one slot |
| master_mode | input | 1 | 1 = bus master (frame sync is the source), 0 = slave |
| long_delay | input | 1 | 0 = 3-slot delay, 1 = 6-slot delay |
| token_out | output | 1 | Token forwarded to the next device |

## Verification
Two events can fall on the same clock edge: a reconfiguration at a frame start, and a token already in the delay line that has not yet emerged. One strobe then latches a new mode and tap, shifts the line, and captures the last slot of the previous frame with the old source selection.

The bench changes mode and select at frame starts and keeps tokens present in all slots. It also toggles both inputs at random mid-frame. Every slot's output is compared against a model that holds the per-slot source history and the per-frame latched setting.

// File: rtl/slot_token_pkg.sv
// Package: shared types for the slot token delay.
// Assumes: nothing beyond plain synthesizable SystemVerilog.
package slot_token_pkg;

    // Per-frame configuration latched at frame start
    typedef struct packed {
        logic master;    // 1 = frame sync is the token source
        logic long_dly;  // 1 = long tap, 0 = short tap
    } tok_cfg_t;

endpackage

// File: rtl/sts_frame_ctrl.sv
// Module: sts_frame_ctrl
// Latches mode and delay select once per frame and flags the first slot of
// each frame.
// Assumes: frame_sync is only high together with slot_strobe.
module sts_frame_ctrl
    import slot_token_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_sync,
    input  logic     slot_strobe,
    input  logic     master_mode,
    input  logic     long_delay,
    output tok_cfg_t cfg,
    output logic     first_slot
);

    logic frame_start;

    assign frame_start = frame_sync & slot_strobe;

    // Capture mode and select only when a frame begins
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (frame_start)
            cfg <= '{master: master_mode, long_dly: long_delay};
    end

    // High for the whole slot that the frame sync opened
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_slot <= 1'b0;
        else if (slot_strobe)
            first_slot <= frame_sync;
    end

    // R7: configuration is held between frame starts
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg));

    // R4: the first-slot flag follows the frame sync seen at each strobe
    a_r4_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        slot_strobe |=> (first_slot == $past(frame_sync)));

endmodule

// File: rtl/sts_delay_line.sv
// Module: sts_delay_line
// Shift line of DEPTH stages that advances on each strobe. The output is
// stage SHORT_TAP or stage DEPTH (counted from 1), chosen by sel_long.
// Assumes: 1 <= SHORT_TAP <= DEPTH.
module sts_delay_line #(
    parameter int DEPTH     = 6,
    parameter int SHORT_TAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic din,
    input  logic sel_long,
    output logic dout
);

    localparam int LONG_IDX  = DEPTH - 1;
    localparam int SHORT_IDX = SHORT_TAP - 1;

    logic [DEPTH-1:0] stage;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            logic nxt;
            if (i == 0) begin : g_head
                assign nxt = din;
            end else begin : g_body
                assign nxt = stage[i-1];
            end

            // One stage of the line, moves only on a slot strobe
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[i] <= 1'b0;
                else if (advance)
                    stage[i] <= nxt;
            end

            if (i > 0) begin : g_chk
                // R2: each stage takes the previous stage's value on a strobe
                a_r2_chain: assert property (@(posedge clk) disable iff (!rst_n)
                    advance |=> (stage[i] == $past(stage[i-1])));
            end
        end
    endgenerate

    // Select the tap for the latched delay
    always_comb begin
        dout = sel_long ? stage[LONG_IDX] : stage[SHORT_IDX];
    end

    // R6: the line is frozen between strobes
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(stage));

    // R2: the first stage captures the source on a strobe
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (stage[0] == $past(din)));

endmodule

// File: rtl/slot_token_delay.sv
// Module: slot_token_delay (top)
// Forwards a token through a TDM daisy chain, delayed by a whole number of
// slots. In master mode the source is the frame's first slot; in slave mode
// it is token_in.
// Assumes: slot_strobe is one clock wide; frame_sync only comes with a strobe;
// token_in is held steady for a whole slot.
module slot_token_delay #(
    parameter int LONG_SLOTS  = 6,
    parameter int SHORT_SLOTS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_sync,
    input  logic slot_strobe,
    input  logic token_in,
    input  logic master_mode,
    input  logic long_delay,
    output logic token_out
);
    import slot_token_pkg::*;

    localparam int LINE_DEPTH = (LONG_SLOTS > SHORT_SLOTS) ? LONG_SLOTS : SHORT_SLOTS;

    tok_cfg_t cfg;
    logic     first_slot;
    logic     src;

    sts_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .slot_strobe (slot_strobe),
        .master_mode (master_mode),
        .long_delay  (long_delay),
        .cfg         (cfg),
        .first_slot  (first_slot)
    );

    // Choose the token source for the current frame's mode
    always_comb begin
        src = cfg.master ? first_slot : token_in;
    end

    sts_delay_line #(
        .DEPTH     (LINE_DEPTH),
        .SHORT_TAP (SHORT_SLOTS)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (slot_strobe),
        .din      (src),
        .sel_long (cfg.long_dly),
        .dout     (token_out)
    );

    // R1: reset drives the output low
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !token_out);

    // R6: the output only moves at a strobe edge
    a_r6_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> $stable(token_out));

endmodule

// File: tb/slot_token_delay_test.sv
module slot_token_delay_test;

    localparam int SLOT_CLKS   = 4;
    localparam int FRAME_SLOTS = 12;
    localparam int NUM_SLOTS   = 720;

    logic clk = 1'b0;
    logic rst_n, frame_sync, slot_strobe, token_in, master_mode, long_delay;
    logic token_out;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;
    bit  hist      [NUM_SLOTS];
    bit  frm_master[NUM_SLOTS];
    bit  frm_long  [NUM_SLOTS];

    always #5 clk = ~clk;

    slot_token_delay uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .slot_strobe (slot_strobe),
        .token_in    (token_in),
        .master_mode (master_mode),
        .long_delay  (long_delay),
        .token_out   (token_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: token_out=%0b expected %0b", tag, act, exp);
        end
    endtask

    // Expected output in slot t: source of slot t-D, with D from t's frame
    function automatic bit expect_out(input int t);
        int d = frm_long[t] ? 6 : 3;
        if (t - d < 0) return 1'b0;
        return hist[t - d];
    endfunction

    function automatic string tag_of(input int t);
        int d = frm_long[t] ? 6 : 3;
        if (t - d < 0) return $sformatf("R1 slot %0d", t);
        if (frm_master[t - d]) return $sformatf("R4 R5 R3 R7 slot %0d", t);
        return $sformatf("R2 R3 R7 slot %0d", t);
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit tok, exp;
        void'($urandom(32'h5A17));
        rst_n = 0; frame_sync = 0; slot_strobe = 0; token_in = 0;
        master_mode = 0; long_delay = 0;

        // R1: strobes and tokens during reset leave the output low
        repeat (4) begin
            @(negedge clk);
            slot_strobe = 1; frame_sync = 1; token_in = 1; master_mode = 1;
            @(negedge clk);
            slot_strobe = 0; frame_sync = 0;
            check(token_out, 1'b0, "R1 during reset");
        end
        @(negedge clk);
        rst_n = 1; token_in = 0; master_mode = 0;
        @(negedge clk);
        check(token_out, 1'b0, "R1 after reset");

        for (int t = 0; t < NUM_SLOTS; t++) begin
            int fi  = t / FRAME_SLOTS;
            int pos = t % FRAME_SLOTS;
            @(negedge clk);
            if (pos == 0) begin
                if (fi < 8) begin
                    master_mode = (fi >= 4);
                    long_delay  = ((fi % 4) >= 2);
                end else begin
                    master_mode = $urandom_range(0, 1);
                    long_delay  = $urandom_range(0, 1);
                end
                frm_master[t] = master_mode;
                frm_long[t]   = long_delay;
            end else begin
                frm_master[t] = frm_master[t-1];
                frm_long[t]   = frm_long[t-1];
            end
            slot_strobe = 1;
            frame_sync  = (pos == 0);
            if (fi < 4) tok = (pos == 1) || (pos == 7) || (pos == 11);
            else        tok = ($urandom_range(0, 3) == 0);
            hist[t] = frm_master[t] ? (pos == 0) : tok;

            @(negedge clk);
            slot_strobe = 0; frame_sync = 0;
            token_in = tok;
            // R7: mid-frame noise on mode and select must have no effect
            if (fi >= 2 && $urandom_range(0, 2) == 0) begin
                master_mode = $urandom_range(0, 1);
                long_delay  = $urandom_range(0, 1);
            end
            exp = expect_out(t);
            check(token_out, exp, tag_of(t));
            repeat (SLOT_CLKS - 2) begin
                @(negedge clk);
                check(token_out, exp, $sformatf("R6 hold slot %0d", t));
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule